// File: doc/BRIEF.md
# Flash Erase Command Sequencer

This controller runs the erase side of a parallel NOR-style flash command interface. An upstream decoder hands it one already-decoded command per cycle, together with a block number. A block-erase command opens a selection window. Each further block-erase command inside that window adds a block and restarts the window. When the window runs out, the controller erases the unprotected blocks of the set one at a time, lowest number first, through a level request to an external erase engine that answers with a done pulse and an error bit. A chip-erase command selects every block at once and has no window.

While an operation is running, every bus read is steered to the status word instead of the array. An erase can be suspended. While it is suspended, reads and programs aimed at blocks outside the selected set pass through as normal. A read of a selected block returns status. A program aimed at a selected or protected block is dropped. Resuming needs a Read/Reset command first, and it needs extended-block mode to be off. A per-block protect vector and cycle-count parameters stand in for the device's protection and timing.

States: ST_IDLE (read mode), ST_SELECT (selection window open), ST_PICK (choose the next block, or finish), ST_ERASE (engine request high), ST_SUSP_WAIT (suspend latency), ST_SUSPENDED, ST_ABORT_WAIT (every selected block protected), ST_FAULT (engine error). Transitions:
- IDLE to SELECT on block-erase. IDLE to PICK on chip-erase.
- SELECT to SELECT on a further block-erase, which reloads the window. SELECT to PICK when the window expires. SELECT to SUSPENDED on suspend. SELECT to IDLE on Read/Reset.
- PICK to ERASE when an unprotected block is left. PICK to IDLE (done) when the set is empty and some block was erased. PICK to ABORT_WAIT when the set is empty and nothing was erased.
- ERASE to PICK on done. ERASE to FAULT on done with error. ERASE to SUSP_WAIT on suspend, but not during chip erase.
- SUSP_WAIT to SUSPENDED when the latency count ends.
- SUSPENDED to PICK on an accepted resume.
- ABORT_WAIT to IDLE (done) when its count ends.
- FAULT to IDLE on Read/Reset.

Top module: `eseq_ctrl`

## Requirements
- R1: A block-erase command (cmd_op 1) in read mode opens a selection window of SEL_CYC cycles. Each further block-erase inside the window adds that block and reloads the full window. Block-erase commands that arrive once erasing has begun are ignored.
- R2: From the cycle after the first block-erase or chip-erase command until the operation ends, every read (rd_en high) gets rd_status = 1, whatever rd_blk is.
- R3: Selected blocks are erased in ascending block number. Protected blocks (protect_mask bit set) are skipped, eng_req is never raised for them, and the error bit stays 0.
- R4: When every selected block is protected, eng_req never rises. The busy bit stays set for about ABORT_CYC cycles after the window ends. The operation then finishes with done = 1 and error = 0.
- R5: After normal completion the controller is in read mode: rd_status = 0 for all reads, the busy bit is 0 and the done bit is 1. After reset all outputs are 0.
- R6: An engine done pulse with eng_err set moves the controller to a fault state. There the error bit is 1, the busy bit is 0 and every read returns status. Read/Reset (cmd_op 5) clears the error and returns the controller to read mode.
- R7: During an operation, only suspend (cmd_op 3) is obeyed. Read/Reset cancels the operation only while the selection window is open, and has no effect once erasing has begun.
- R8: A suspend inside the selection window sets the suspended bit on the next cycle. A suspend while a block erase is running drops eng_req on the next cycle and sets the suspended bit SUSP_CYC+1 cycles later.
- R9: While suspended, a read of a block in the selected set returns status (rd_status = 1). A read of any other block returns array data (rd_status = 0).
- R10: A program request is passed on (prog_go = 1 in the same cycle) only to an unprotected block, and only in read mode or, while suspended, to a block outside the selected set. In every other case it is dropped.
- R11: Resume (cmd_op 4) while suspended is obeyed only if Read/Reset has been given since suspension and extended-block mode is off. Extended-block mode is entered with cmd_op 6 and left with cmd_op 7. Otherwise resume is ignored. After a resume, erasing continues and finishes.
- R12: Chip erase (cmd_op 2) erases every unprotected block in ascending order, and suspend has no effect during it.
- R13: The status word bits are: bit 0 toggle, bit 1 busy, bit 2 suspended, bit 3 error, bit 4 done, with the upper bits 0. The toggle bit inverts after each status read taken while busy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Decoded command present this cycle |
| cmd_op | input | 3 | Command code: 1 block-erase, 2 chip-erase, 3 suspend, 4 resume, 5 read/reset, 6 enter extended block, 7 leave extended block |
| cmd_blk | input | BW | Block number carried by the command |
| rd_en | input | 1 | Bus read this cycle |
| rd_blk | input | BW | Block addressed by the read |
| rd_status | output | 1 | 1: the read returns the status word; 0: it returns array data |
| status_word | output | 8 | Status register contents |
| prog_valid | input | 1 | Program request this cycle |
| prog_blk | input | BW | Block targeted by the program request |
| prog_go | output | 1 | Program request accepted and passed to the array |
| protect_mask | input | NUM_BLK | Per-block protection, 1 = protected |
| eng_req | output | 1 | Erase engine request for block eng_blk (level) |
| eng_blk | output | BW | Block being erased |
| eng_done | input | 1 | One-cycle pulse: current block finished |
| eng_err | input | 1 | Error qualifier that comes with eng_done |

## Verification
The assertions take protect_mask as steady for the whole of an operation, eng_done as a single-cycle pulse that comes only while eng_req is high, and at most one decoded command per cycle. The bench changes the protect vector only while the controller is idle or between operations. Its engine model counts progress only while eng_req is high, holds that progress while the request is dropped, and emits exactly one done pulse per block with the request still high. Every command, read and program is driven for one cycle, at a falling edge, so no two commands ever fall in the same cycle.

// File: rtl/eseq_pkg.sv
package eseq_pkg;

    typedef enum logic [2:0] {
        OP_NONE       = 3'd0,
        OP_BLK_ERASE  = 3'd1,
        OP_CHIP_ERASE = 3'd2,
        OP_SUSPEND    = 3'd3,
        OP_RESUME     = 3'd4,
        OP_RESET      = 3'd5,
        OP_EXT_ENTER  = 3'd6,
        OP_EXT_EXIT   = 3'd7
    } op_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SELECT,
        ST_PICK,
        ST_ERASE,
        ST_SUSP_WAIT,
        ST_SUSPENDED,
        ST_ABORT_WAIT,
        ST_FAULT
    } state_e;

    localparam int STAT_TOG  = 0;
    localparam int STAT_BUSY = 1;
    localparam int STAT_SUSP = 2;
    localparam int STAT_ERR  = 3;
    localparam int STAT_DONE = 4;

endpackage

// File: rtl/eseq_timer.sv
module eseq_timer #(
    parameter int TW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [TW-1:0] load_val,
    input  logic          run,
    output logic [TW-1:0] count,
    output logic          expired
);
    logic [TW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (load)
            cnt_q <= load_val;
        else if (run && cnt_q != '0)
            cnt_q <= cnt_q - 1'b1;
    end

    assign count   = cnt_q;
    assign expired = (cnt_q == '0);

    // R1 window counts down steadily while running and not reloaded
    assert_timer_steps_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !load && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1));

endmodule

// File: rtl/eseq_low_pick.sv
module eseq_low_pick #(
    parameter int N  = 8,
    parameter int BW = 3
) (
    input  logic [N-1:0]  vec,
    output logic [BW-1:0] idx
);
    logic [N:0]   seen_below;
    logic [N-1:0] hit;

    assign seen_below[0] = 1'b0;

    for (genvar g = 0; g < N; g++) begin : g_scan
        assign hit[g]          = vec[g] & ~seen_below[g];
        assign seen_below[g+1] = seen_below[g] | vec[g];
    end

    always_comb begin
        idx = '0;
        for (int i = 0; i < N; i++)
            if (hit[i]) idx = idx | BW'(i);
    end

endmodule

// File: rtl/eseq_rd_router.sv
module eseq_rd_router #(
    parameter int N  = 8,
    parameter int BW = 3
) (
    input  logic          route_all,
    input  logic          susp_mode,
    input  logic [N-1:0]  susp_set,
    input  logic [BW-1:0] rd_blk,
    input  logic          tog,
    input  logic          busy,
    input  logic          err,
    input  logic          done,
    output logic          rd_status,
    output logic [7:0]    status_word
);
    import eseq_pkg::*;

    assign rd_status = route_all | (susp_mode & susp_set[rd_blk]);

    always_comb begin
        status_word            = '0;
        status_word[STAT_TOG]  = tog;
        status_word[STAT_BUSY] = busy;
        status_word[STAT_SUSP] = susp_mode;
        status_word[STAT_ERR]  = err;
        status_word[STAT_DONE] = done;
    end

endmodule

// File: rtl/eseq_ctrl.sv
module eseq_ctrl #(
    parameter int NUM_BLK   = 8,
    parameter int SEL_CYC   = 20,
    parameter int SUSP_CYC  = 6,
    parameter int ABORT_CYC = 30,
    localparam int BW = $clog2(NUM_BLK)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cmd_valid,
    input  logic [2:0]         cmd_op,
    input  logic [BW-1:0]      cmd_blk,
    input  logic               rd_en,
    input  logic [BW-1:0]      rd_blk,
    output logic               rd_status,
    output logic [7:0]         status_word,
    input  logic               prog_valid,
    input  logic [BW-1:0]      prog_blk,
    output logic               prog_go,
    input  logic [NUM_BLK-1:0] protect_mask,
    output logic               eng_req,
    output logic [BW-1:0]      eng_blk,
    input  logic               eng_done,
    input  logic               eng_err
);
    import eseq_pkg::*;

    localparam int MAX_AB = (SEL_CYC > SUSP_CYC) ? SEL_CYC : SUSP_CYC;
    localparam int MAXC   = (MAX_AB > ABORT_CYC) ? MAX_AB : ABORT_CYC;
    localparam int TW     = $clog2(MAXC + 1);

    state_e state, state_n;
    op_e    op;

    logic [NUM_BLK-1:0] sel_mask, mask_n, eff_mask, cmd_bit, cur_bit;
    logic               chip_q, chip_n, started_q, started_n;
    logic               rsn_q, rsn_n, ext_q, ext_n;
    logic               err_q, err_n, done_q, done_n, tog_q, tog_n;
    logic               tmr_load, tmr_run, tmr_zero;
    logic [TW-1:0]      tmr_val, tmr_count;
    logic [BW-1:0]      cur_idx;
    logic               busy, route_all, susp_mode;

    assign op       = cmd_valid ? op_e'(cmd_op) : OP_NONE;
    assign cmd_bit  = NUM_BLK'(1) << cmd_blk;
    assign eff_mask = sel_mask & ~protect_mask;
    assign cur_bit  = NUM_BLK'(1) << cur_idx;

    eseq_low_pick #(.N(NUM_BLK), .BW(BW)) u_pick (
        .vec (sel_mask),
        .idx (cur_idx)
    );

    eseq_timer #(.TW(TW)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .run      (tmr_run),
        .count    (tmr_count),
        .expired  (tmr_zero)
    );

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_n;
    end

    // held data registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sel_mask  <= '0;
            chip_q    <= 1'b0;
            started_q <= 1'b0;
            rsn_q     <= 1'b0;
            ext_q     <= 1'b0;
            err_q     <= 1'b0;
            done_q    <= 1'b0;
            tog_q     <= 1'b0;
        end else begin
            sel_mask  <= mask_n;
            chip_q    <= chip_n;
            started_q <= started_n;
            rsn_q     <= rsn_n;
            ext_q     <= ext_n;
            err_q     <= err_n;
            done_q    <= done_n;
            tog_q     <= tog_n;
        end
    end

    // next state and controls
    always_comb begin
        state_n   = state;
        mask_n    = sel_mask;
        chip_n    = chip_q;
        started_n = started_q;
        rsn_n     = rsn_q;
        ext_n     = ext_q;
        err_n     = err_q;
        done_n    = done_q;
        tmr_load  = 1'b0;
        tmr_val   = TW'(SEL_CYC);
        unique case (state)
            ST_IDLE: begin
                if (op == OP_BLK_ERASE) begin
                    mask_n    = cmd_bit;
                    chip_n    = 1'b0;
                    started_n = 1'b0;
                    done_n    = 1'b0;
                    tmr_load  = 1'b1;
                    state_n   = ST_SELECT;
                end else if (op == OP_CHIP_ERASE) begin
                    mask_n    = '1;
                    chip_n    = 1'b1;
                    started_n = 1'b0;
                    done_n    = 1'b0;
                    state_n   = ST_PICK;
                end
            end
            ST_SELECT: begin
                if (op == OP_SUSPEND) begin
                    rsn_n   = 1'b0;
                    ext_n   = 1'b0;
                    state_n = ST_SUSPENDED;
                end else if (op == OP_RESET) begin
                    mask_n  = '0;
                    state_n = ST_IDLE;
                end else if (op == OP_BLK_ERASE) begin
                    mask_n   = sel_mask | cmd_bit;
                    tmr_load = 1'b1;
                end else if (tmr_zero) begin
                    state_n = ST_PICK;
                end
            end
            ST_PICK: begin
                if (eff_mask == '0) begin
                    mask_n = '0;
                    if (started_q) begin
                        done_n  = 1'b1;
                        state_n = ST_IDLE;
                    end else begin
                        tmr_load = 1'b1;
                        tmr_val  = TW'(ABORT_CYC);
                        state_n  = ST_ABORT_WAIT;
                    end
                end else begin
                    mask_n    = eff_mask;
                    started_n = 1'b1;
                    state_n   = ST_ERASE;
                end
            end
            ST_ERASE: begin
                if (eng_done) begin
                    mask_n = sel_mask & ~cur_bit;
                    if (eng_err) begin
                        err_n   = 1'b1;
                        state_n = ST_FAULT;
                    end else begin
                        state_n = ST_PICK;
                    end
                end else if (op == OP_SUSPEND && !chip_q) begin
                    tmr_load = 1'b1;
                    tmr_val  = TW'(SUSP_CYC);
                    state_n  = ST_SUSP_WAIT;
                end
            end
            ST_SUSP_WAIT: begin
                if (tmr_zero) begin
                    rsn_n   = 1'b0;
                    ext_n   = 1'b0;
                    state_n = ST_SUSPENDED;
                end
            end
            ST_SUSPENDED: begin
                if (op == OP_RESET)
                    rsn_n = 1'b1;
                else if (op == OP_EXT_ENTER)
                    ext_n = 1'b1;
                else if (op == OP_EXT_EXIT)
                    ext_n = 1'b0;
                else if (op == OP_RESUME && rsn_q && !ext_q)
                    state_n = ST_PICK;
            end
            ST_ABORT_WAIT: begin
                if (tmr_zero) begin
                    done_n  = 1'b1;
                    state_n = ST_IDLE;
                end
            end
            ST_FAULT: begin
                if (op == OP_RESET) begin
                    err_n   = 1'b0;
                    mask_n  = '0;
                    state_n = ST_IDLE;
                end
            end
            default: state_n = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        busy      = (state == ST_SELECT) || (state == ST_PICK) || (state == ST_ERASE) ||
                    (state == ST_SUSP_WAIT) || (state == ST_ABORT_WAIT);
        route_all = busy || (state == ST_FAULT);
        susp_mode = (state == ST_SUSPENDED);
        tmr_run   = (state == ST_SELECT) || (state == ST_SUSP_WAIT) || (state == ST_ABORT_WAIT);
        eng_req   = (state == ST_ERASE);
        eng_blk   = cur_idx;
        prog_go   = prog_valid && !protect_mask[prog_blk] &&
                    ((state == ST_IDLE) || (susp_mode && !sel_mask[prog_blk]));
        tog_n     = (rd_en && busy) ? ~tog_q : tog_q;
    end

    eseq_rd_router #(.N(NUM_BLK), .BW(BW)) u_route (
        .route_all   (route_all),
        .susp_mode   (susp_mode),
        .susp_set    (sel_mask),
        .rd_blk      (rd_blk),
        .tog         (tog_q),
        .busy        (busy),
        .err         (err_q),
        .done        (done_q),
        .rd_status   (rd_status),
        .status_word (status_word)
    );

    // R1 a further selection reloads the full window
    assert_sel_restart_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SELECT && op == OP_BLK_ERASE) |=> (tmr_count == TW'(SEL_CYC)));

    // R2 reads during an operation see status
    assert_busy_route_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && state != ST_IDLE && state != ST_SUSPENDED) |-> rd_status);

    // R3 the engine never works on a protected block
    assert_no_prot_erase_R3: assert property (@(posedge clk) disable iff (!rst_n)
        eng_req |-> !protect_mask[eng_blk]);

    // R4 the protected-only interval ends in a clean done
    assert_abort_exit_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_ABORT_WAIT) |=>
        (state == ST_ABORT_WAIT || (state == ST_IDLE && done_q && !err_q)));

    // R6 fault persists until read/reset
    assert_fault_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_FAULT && op != OP_RESET) |=> (state == ST_FAULT && err_q));

    // R7 read/reset has no effect once erasing has begun
    assert_erase_ignore_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_ERASE && op == OP_RESET && !eng_done) |=> eng_req);

    // R8 suspend during an erase releases the engine at once
    assert_susp_drop_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (eng_req && !chip_q && op == OP_SUSPEND && !eng_done) |=> !eng_req);

    // R10 no program reaches a suspended block
    assert_prog_guard_R10: assert property (@(posedge clk) disable iff (!rst_n)
        prog_go |-> !(rd_status && rd_en && rd_blk == prog_blk));

    // R11 resume is gated while suspended
    assert_resume_gate_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SUSPENDED && (!rsn_q || ext_q)) |=> (state == ST_SUSPENDED));

    // R12 no suspend during chip erase
    assert_chip_nosusp_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (chip_q && state == ST_ERASE) |=> (state != ST_SUSP_WAIT));

    // R13 toggle inverts on each status read while busy
    assert_toggle_R13: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && status_word[STAT_BUSY]) |=> (status_word[STAT_TOG] != $past(status_word[STAT_TOG])));

endmodule

// File: tb/tb_eseq_ctrl.sv
`timescale 1ns/100ps
module tb_eseq_ctrl;
    import eseq_pkg::*;

    localparam int NB    = 8;
    localparam int BW    = 3;
    localparam int SEL   = 20;
    localparam int SUSP  = 6;
    localparam int ABRT  = 30;
    localparam int ENG   = 10;

    // stimulus vectors used while suspended with set {2,6} and block 4 protected
    // {kind(1=program,0=read), blk[2:0], expected rd_status or prog_go}
    localparam logic [4:0] SVEC [8] = '{
        5'b0_010_1, 5'b0_110_1, 5'b0_000_0, 5'b0_100_0,
        5'b1_000_1, 5'b1_010_0, 5'b1_100_0, 5'b1_111_1
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cmd_valid = 1'b0;
    logic [2:0]    cmd_op = 3'd0;
    logic [BW-1:0] cmd_blk = '0;
    logic          rd_en = 1'b0;
    logic [BW-1:0] rd_blk = '0;
    logic          rd_status;
    logic [7:0]    status_word;
    logic          prog_valid = 1'b0;
    logic [BW-1:0] prog_blk = '0;
    logic          prog_go;
    logic [NB-1:0] protect_mask = '0;
    logic          eng_req;
    logic [BW-1:0] eng_blk;
    logic          eng_done = 1'b0;
    logic          eng_err = 1'b0;

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 1'b0;
    int elog [0:31];
    int nlog = 0;
    int eprog = 0;
    int err_blk = -1;

    eseq_ctrl #(.NUM_BLK(NB), .SEL_CYC(SEL), .SUSP_CYC(SUSP), .ABORT_CYC(ABRT)) dut (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_blk(cmd_blk),
        .rd_en(rd_en), .rd_blk(rd_blk), .rd_status(rd_status), .status_word(status_word),
        .prog_valid(prog_valid), .prog_blk(prog_blk), .prog_go(prog_go),
        .protect_mask(protect_mask), .eng_req(eng_req), .eng_blk(eng_blk),
        .eng_done(eng_done), .eng_err(eng_err)
    );

    always #2 clk = ~clk;

    // erase engine model: progress only while requested, one done pulse per block
    always @(posedge clk) begin
        if (!rst_n) begin
            eng_done <= 1'b0;
            eng_err  <= 1'b0;
            eprog    = 0;
        end else begin
            eng_done <= 1'b0;
            eng_err  <= 1'b0;
            if (eng_req && !eng_done) begin
                if (eprog == ENG - 1) begin
                    eng_done <= 1'b1;
                    eng_err  <= (int'(eng_blk) == err_blk);
                    eprog    = 0;
                    if (nlog < 32) elog[nlog] = int'(eng_blk);
                    nlog = nlog + 1;
                end else begin
                    eprog = eprog + 1;
                end
            end
        end
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic cmd(input op_e op, input int b);
        @(negedge clk);
        cmd_valid = 1'b1; cmd_op = op; cmd_blk = BW'(b);
        @(posedge clk); #1;
        cmd_valid = 1'b0; cmd_op = 3'd0;
    endtask

    task automatic rd(input int b, output bit st, output logic [7:0] w);
        @(negedge clk);
        rd_en = 1'b1; rd_blk = BW'(b);
        #0.5;
        st = rd_status; w = status_word;
        @(posedge clk); #1;
        rd_en = 1'b0;
    endtask

    task automatic prog(input int b, output bit go);
        @(negedge clk);
        prog_valid = 1'b1; prog_blk = BW'(b);
        #0.5;
        go = prog_go;
        @(posedge clk); #1;
        prog_valid = 1'b0;
    endtask

    task automatic idle_wait(output int cyc);
        bit st; logic [7:0] w;
        cyc = 0;
        for (int i = 0; i < 3000; i++) begin
            rd(0, st, w);
            cyc++;
            if (!w[STAT_BUSY]) break;
        end
    endtask

    task automatic wait_eng();
        for (int i = 0; i < 3000; i++) begin
            @(negedge clk);
            if (eng_req) break;
        end
    endtask

    initial begin
        #(200000 * 4);
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        bit st, st2, go;
        logic [7:0] w, w2;
        int cyc;

        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk); #0.5;
        // R5 reset state
        chk(rd_status == 1'b0 && status_word == 8'h00 && !eng_req && !prog_go,
            "R5 reset outputs", int'(status_word), 0);

        // R10 programs in read mode
        protect_mask = 8'h10;
        prog(0, go); chk(go == 1'b1, "R10 idle program unprotected", int'(go), 1);
        prog(4, go); chk(go == 1'b0, "R10 idle program protected", int'(go), 0);

        // R1 R2 R3 R13 multi-block selection with restarting window
        protect_mask = 8'h04; nlog = 0;
        cmd(OP_BLK_ERASE, 5);
        rd(3, st, w);
        chk(st == 1'b1, "R2 status routed in window", int'(st), 1);
        rd(3, st2, w2);
        chk(w[STAT_TOG] != w2[STAT_TOG], "R13 toggle inverts", int'(w2[STAT_TOG]), int'(~w[STAT_TOG]));
        chk(w2[7:5] == 3'b000 && w2[STAT_BUSY], "R13 busy bit and upper zero", int'(w2), 2);
        repeat (13) @(negedge clk);
        cmd(OP_BLK_ERASE, 2);
        repeat (15) @(negedge clk);
        cmd(OP_BLK_ERASE, 1);
        wait_eng();
        chk(eng_blk == 3'd1, "R3 lowest block first", int'(eng_blk), 1);
        prog(0, go); chk(go == 1'b0, "R10 program dropped while erasing", int'(go), 0);
        cmd(OP_BLK_ERASE, 7);
        cmd(OP_RESET, 0);
        rd(6, st, w);
        chk(st == 1'b1 && w[STAT_BUSY], "R7 reset ignored during erase", int'(st), 1);
        idle_wait(cyc);
        chk(nlog == 2, "R1 window restart and late select ignored count", nlog, 2);
        chk(elog[0] == 1 && elog[1] == 5, "R3 ascending skip protected", elog[1], 5);
        rd(5, st, w);
        chk(st == 1'b0 && w[STAT_DONE] && !w[STAT_ERR] && !w[STAT_BUSY],
            "R5 back in read mode with done", int'(w), 16);

        // R4 every selected block protected
        protect_mask = 8'h08; nlog = 0;
        cmd(OP_BLK_ERASE, 3);
        idle_wait(cyc);
        chk(cyc >= SEL + ABRT && cyc <= SEL + ABRT + 8, "R4 abort interval length", cyc, SEL + ABRT + 3);
        chk(nlog == 0, "R4 no engine request", nlog, 0);
        rd(0, st, w);
        chk(w[STAT_DONE] && !w[STAT_ERR], "R4 done without error", int'(w), 16);

        // R7 read/reset inside window cancels
        protect_mask = 8'h00; nlog = 0;
        cmd(OP_BLK_ERASE, 4);
        cmd(OP_RESET, 0);
        rd(4, st, w);
        chk(st == 1'b0 && !w[STAT_BUSY], "R7 reset in window returns to read", int'(st), 0);
        repeat (40) @(negedge clk);
        chk(nlog == 0, "R7 cancelled selection not erased", nlog, 0);

        // R6 engine error
        err_blk = 3; nlog = 0;
        cmd(OP_BLK_ERASE, 3);
        cmd(OP_BLK_ERASE, 6);
        idle_wait(cyc);
        rd(0, st, w);
        chk(st == 1'b1 && w[STAT_ERR] && !w[STAT_BUSY], "R6 fault routes status", int'(w), 8);
        chk(nlog == 1, "R6 erase stops at failing block", nlog, 1);
        cmd(OP_RESET, 0);
        rd(0, st, w);
        chk(st == 1'b0 && !w[STAT_ERR], "R6 reset clears fault", int'(w[STAT_ERR]), 0);
        err_blk = -1;

        // R8 R9 R10 R11 suspend in window
        protect_mask = 8'h10; nlog = 0;
        cmd(OP_BLK_ERASE, 2);
        cmd(OP_BLK_ERASE, 6);
        cmd(OP_SUSPEND, 0);
        rd(0, st, w);
        chk(w[STAT_SUSP] == 1'b1 && !eng_req, "R8 suspend in window immediate", int'(w[STAT_SUSP]), 1);
        for (int i = 0; i < 8; i++) begin
            if (SVEC[i][4]) begin
                prog(int'(SVEC[i][3:1]), go);
                chk(go == SVEC[i][0], "R10 program while suspended", int'(go), int'(SVEC[i][0]));
            end else begin
                rd(int'(SVEC[i][3:1]), st, w);
                chk(st == SVEC[i][0], "R9 read routing while suspended", int'(st), int'(SVEC[i][0]));
            end
        end
        cmd(OP_RESUME, 0);
        rd(0, st, w);
        chk(w[STAT_SUSP] == 1'b1, "R11 resume before reset ignored", int'(w[STAT_SUSP]), 1);
        cmd(OP_RESET, 0);
        cmd(OP_EXT_ENTER, 0);
        cmd(OP_RESUME, 0);
        rd(0, st, w);
        chk(w[STAT_SUSP] == 1'b1, "R11 resume in extended mode ignored", int'(w[STAT_SUSP]), 1);
        cmd(OP_EXT_EXIT, 0);
        cmd(OP_RESUME, 0);
        rd(0, st, w);
        chk(!w[STAT_SUSP] && w[STAT_BUSY], "R11 resume accepted", int'(w), 2);
        idle_wait(cyc);
        chk(nlog == 2 && elog[0] == 2 && elog[1] == 6, "R11 erase completes after resume", nlog, 2);

        // R8 suspend during a block erase
        protect_mask = 8'h00; nlog = 0;
        cmd(OP_BLK_ERASE, 1);
        wait_eng();
        repeat (3) @(negedge clk);
        cmd(OP_SUSPEND, 0);
        chk(eng_req == 1'b0, "R8 engine request dropped", int'(eng_req), 0);
        rd(0, st, w);
        chk(w[STAT_SUSP] == 1'b0, "R8 latency not yet over", int'(w[STAT_SUSP]), 0);
        repeat (SUSP + 2) @(negedge clk);
        rd(0, st, w);
        chk(w[STAT_SUSP] == 1'b1, "R8 suspended after latency", int'(w[STAT_SUSP]), 1);
        cmd(OP_RESET, 0);
        cmd(OP_RESUME, 0);
        idle_wait(cyc);
        chk(nlog == 1 && elog[0] == 1, "R8 resumed block finished", nlog, 1);

        // R12 chip erase ignores suspend
        protect_mask = 8'h81; nlog = 0;
        cmd(OP_CHIP_ERASE, 0);
        wait_eng();
        cmd(OP_SUSPEND, 0);
        repeat (SUSP + 4) @(negedge clk);
        rd(0, st, w);
        chk(!w[STAT_SUSP] && w[STAT_BUSY], "R12 suspend ignored in chip erase", int'(w[STAT_SUSP]), 0);
        idle_wait(cyc);
        chk(nlog == 6, "R12 chip erase block count", nlog, 6);
        for (int i = 0; i < 6; i++)
            chk(elog[i] == i + 1, "R12 chip erase order", elog[i], i + 1);

        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

endmodule